// File: doc/BRIEF.md
# Large Core Acceleration Coordinator

This block decides, for each large core of an asymmetric multicore, which piece of work runs on it. At every scheduling quantum boundary it ranks up to `NUM_CAND` lagging-thread candidates by utility. It then hands the highest-utility candidate to core 0, the next one to core 1, and so on, with one thread per core. Between quantum boundaries, bottleneck requests arrive on a valid/ready stream. Each request carries an ID, a utility value and a target core.

A request whose utility is strictly above the programmable threshold is acted on, and any other request is dropped with a reject pulse. If the target core is running its lagging thread, the bottleneck preempts that thread. If a bottleneck already occupies the core, the new one waits in that core's own FIFO. When a running bottleneck signals completion, the oldest queued bottleneck takes over. If none is queued, the lagging thread that the core currently holds is restored. The block produces a grant per core and one-cycle preempt and restore pulses. It does not move any context.

The request stream never applies back-pressure: `bn_ready_o` is high whenever reset is released. Every request that is offered while ready is high is consumed in that cycle. The outcome is an action or a reject pulse. All outputs are registered and change at the clock edge that samples the causing inputs.

Top module: `lca_coordinator`

## Requirements
- R1: While reset is low, and after it is released with no further stimulus, every grant valid, preempt, restore and reject output is 0, and `bn_ready_o` is 0 during reset and 1 after it.
- R2: On a `quantum_i` cycle, valid candidates are ordered by descending utility, with equal utilities ordered by lower candidate index first. Rank k goes to core k. A core with no candidate of its rank shows grant valid 0 while it runs lagging work.
- R3: A valid request with utility less than or equal to `bn_thresh_i`, or with a core index of `NUM_CORES` or above, is dropped. One cycle later `bn_reject_o` pulses, and no grant changes.
- R4: An eligible request for a core running its lagging thread preempts it. On the next edge the grant shows `grant_is_bn_o`=1 with the request ID, and that core's `preempt_o` pulses for one cycle.
- R5: An eligible request for a core whose bottleneck is running is appended to that core's FIFO of depth `BUF_DEPTH`. The running grant is left unchanged.
- R6: When `bn_done_i[k]` is high and core k's FIFO is non-empty, the oldest entry becomes the running bottleneck. When the FIFO is empty, the core returns to its saved lagging thread and `restore_o[k]` pulses once. A done pulse while the core runs lagging work has no effect.
- R7: An eligible request for a core whose FIFO is full, with no done in the same cycle, is rejected with a `bn_reject_o` pulse, and the FIFO contents are unchanged.
- R8: A quantum boundary while core k runs a bottleneck changes only the saved lagging thread of core k. The bottleneck grant stays as it is.
- R9: If a done and an eligible request for the same core fall in the same cycle and the FIFO is empty, the new bottleneck runs directly. Neither preempt nor restore pulses.
- R10: A request or done for one core does not change any other core's grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quantum_i | input | 1 | Quantum boundary pulse |
| cand_valid_i | input | NUM_CAND | Candidate present flags |
| cand_id_i | input | NUM_CAND*ID_W | Candidate thread IDs, candidate i at bits i*ID_W |
| cand_util_i | input | NUM_CAND*UTIL_W | Candidate utilities, candidate i at bits i*UTIL_W |
| bn_thresh_i | input | UTIL_W | Bottleneck utility threshold |
| bn_valid_i | input | 1 | Bottleneck request valid |
| bn_ready_o | output | 1 | Request ready, high out of reset |
| bn_id_i | input | ID_W | Bottleneck ID |
| bn_util_i | input | UTIL_W | Bottleneck utility |
| bn_core_i | input | CORE_W | Target large core |
| bn_done_i | input | NUM_CORES | Per-core running bottleneck finished |
| grant_valid_o | output | NUM_CORES | Core has work granted |
| grant_is_bn_o | output | NUM_CORES | Granted work is a bottleneck |
| grant_id_o | output | NUM_CORES*ID_W | Granted ID, core k at bits k*ID_W |
| preempt_o | output | NUM_CORES | Lagging thread preempted pulse |
| restore_o | output | NUM_CORES | Lagging thread restored pulse |
| bn_reject_o | output | 1 | Request dropped pulse |

## Verification
Two functions of one core can fall in the same cycle: completion of the running bottleneck and arrival of a new eligible request for that core. The bench provokes this by raising `bn_done_i` for a core in the same cycle as a request aimed at it, with the FIFO empty. It judges the result by checking that the new ID is granted and that neither a preempt nor a restore pulse appears. A second collision is a quantum boundary while a bottleneck runs. For that case the bench checks that the bottleneck grant is untouched and that the thread restored later is the one assigned at that quantum.

// File: rtl/lca_pkg.sv
package lca_pkg;
  typedef enum logic {
    SLOT_LT = 1'b0,
    SLOT_BN = 1'b1
  } slot_mode_e;
endpackage

// File: rtl/lca_lt_ranker.sv
module lca_lt_ranker #(
  parameter int NUM_CAND  = 4,
  parameter int NUM_CORES = 2,
  parameter int ID_W      = 6,
  parameter int UTIL_W    = 8
) (
  input  logic [NUM_CAND-1:0]        cand_valid_i,
  input  logic [NUM_CAND*ID_W-1:0]   cand_id_i,
  input  logic [NUM_CAND*UTIL_W-1:0] cand_util_i,
  output logic [NUM_CORES-1:0]       sel_valid_o,
  output logic [NUM_CORES*ID_W-1:0]  sel_id_o
);
  localparam int RW = $clog2(NUM_CAND + 1);

  logic [RW-1:0] rank [NUM_CAND];

  // rank = number of valid candidates that beat this one
  always_comb begin
    for (int i = 0; i < NUM_CAND; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NUM_CAND; j++) begin
        if (j != i && cand_valid_i[j]) begin
          if ((cand_util_i[j*UTIL_W +: UTIL_W] > cand_util_i[i*UTIL_W +: UTIL_W]) ||
              ((cand_util_i[j*UTIL_W +: UTIL_W] == cand_util_i[i*UTIL_W +: UTIL_W]) && (j < i)))
            rank[i] = rank[i] + 1'b1;
        end
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_CORES; k++) begin : g_core
      always_comb begin
        sel_valid_o[k] = 1'b0;
        sel_id_o[k*ID_W +: ID_W] = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
          if (cand_valid_i[i] && (rank[i] == RW'(k))) begin
            sel_valid_o[k] = 1'b1;
            sel_id_o[k*ID_W +: ID_W] = cand_id_i[i*ID_W +: ID_W];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lca_bn_fifo.sv
module lca_bn_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      if (push_i && !pop_i)      count <= count + 1'b1;
      else if (pop_i && !push_i) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lca_core_slot.sv
module lca_core_slot
  import lca_pkg::*;
#(
  parameter int ID_W  = 6,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            quantum_i,
  input  logic            q_lt_valid_i,
  input  logic [ID_W-1:0] q_lt_id_i,
  input  logic            req_i,
  input  logic [ID_W-1:0] req_id_i,
  input  logic            done_i,
  output logic            grant_valid_o,
  output logic            grant_is_bn_o,
  output logic [ID_W-1:0] grant_id_o,
  output logic            preempt_o,
  output logic            restore_o,
  output logic            reject_o
);
  slot_mode_e      mode_q;
  logic [ID_W-1:0] bn_id_q, lt_id_q, head;
  logic            lt_valid_q;
  logic            fifo_empty, fifo_full;
  logic            free, pop, push, rej;

  // core can take a request directly: lagging work, or bottleneck ending with nothing queued
  assign free = (mode_q == SLOT_LT) || (done_i && fifo_empty);
  assign pop  = (mode_q == SLOT_BN) && done_i && !fifo_empty;
  assign push = req_i && !free && (!fifo_full || pop);
  assign rej  = req_i && !free && fifo_full && !pop;

  lca_bn_fifo #(.W(ID_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  (req_id_i),
    .data_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= SLOT_LT;
      bn_id_q    <= '0;
      lt_id_q    <= '0;
      lt_valid_q <= 1'b0;
      preempt_o  <= 1'b0;
      restore_o  <= 1'b0;
      reject_o   <= 1'b0;
    end else begin
      preempt_o <= 1'b0;
      restore_o <= 1'b0;
      reject_o  <= rej;
      if (quantum_i) begin
        lt_valid_q <= q_lt_valid_i;
        lt_id_q    <= q_lt_id_i;
      end
      if (mode_q == SLOT_LT) begin
        if (req_i) begin
          mode_q    <= SLOT_BN;
          bn_id_q   <= req_id_i;
          preempt_o <= 1'b1;
        end
      end else if (pop) begin
        bn_id_q <= head;
      end else if (done_i) begin
        if (req_i) begin
          bn_id_q <= req_id_i;
        end else begin
          mode_q    <= SLOT_LT;
          restore_o <= 1'b1;
        end
      end
    end
  end

  assign grant_is_bn_o = (mode_q == SLOT_BN);
  assign grant_valid_o = grant_is_bn_o || lt_valid_q;
  assign grant_id_o    = grant_is_bn_o ? bn_id_q : lt_id_q;

  assert_preempt_runs_bn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |-> (grant_is_bn_o && !restore_o));
  assert_restore_runs_lt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> !grant_is_bn_o);
  assert_done_idle_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_is_bn_o && done_i && !req_i && !quantum_i) |=> (!restore_o && $stable(grant_id_o)));
  assert_quantum_keeps_bn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quantum_i && grant_is_bn_o && !done_i) |=> (grant_is_bn_o && $stable(grant_id_o)));
  assert_full_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && grant_is_bn_o && !done_i && fifo_full) |=> (reject_o && $stable(grant_id_o)));
  assert_enqueue_keeps_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && grant_is_bn_o && !done_i) |=> (grant_is_bn_o && $stable(grant_id_o)));
  assert_direct_handover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && grant_is_bn_o && done_i && fifo_empty) |=> (grant_is_bn_o && !restore_o && !preempt_o));
endmodule

// File: rtl/lca_coordinator.sv
module lca_coordinator #(
  parameter int NUM_CORES = 2,
  parameter int NUM_CAND  = 4,
  parameter int ID_W      = 6,
  parameter int UTIL_W    = 8,
  parameter int BUF_DEPTH = 2,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       quantum_i,
  input  logic [NUM_CAND-1:0]        cand_valid_i,
  input  logic [NUM_CAND*ID_W-1:0]   cand_id_i,
  input  logic [NUM_CAND*UTIL_W-1:0] cand_util_i,
  input  logic [UTIL_W-1:0]          bn_thresh_i,
  input  logic                       bn_valid_i,
  output logic                       bn_ready_o,
  input  logic [ID_W-1:0]            bn_id_i,
  input  logic [UTIL_W-1:0]          bn_util_i,
  input  logic [CORE_W-1:0]          bn_core_i,
  input  logic [NUM_CORES-1:0]       bn_done_i,
  output logic [NUM_CORES-1:0]       grant_valid_o,
  output logic [NUM_CORES-1:0]       grant_is_bn_o,
  output logic [NUM_CORES*ID_W-1:0]  grant_id_o,
  output logic [NUM_CORES-1:0]       preempt_o,
  output logic [NUM_CORES-1:0]       restore_o,
  output logic                       bn_reject_o
);
  logic [NUM_CORES-1:0]      sel_valid;
  logic [NUM_CORES*ID_W-1:0] sel_id;
  logic [NUM_CORES-1:0]      slot_rej;
  logic                      above, core_ok, eligible, drop_q;

  assign bn_ready_o = rst_n;
  assign above      = bn_util_i > bn_thresh_i;
  assign core_ok    = {1'b0, bn_core_i} < (CORE_W + 1)'(NUM_CORES);
  assign eligible   = bn_valid_i && above && core_ok;

  lca_lt_ranker #(
    .NUM_CAND (NUM_CAND),
    .NUM_CORES(NUM_CORES),
    .ID_W     (ID_W),
    .UTIL_W   (UTIL_W)
  ) u_ranker (
    .cand_valid_i (cand_valid_i),
    .cand_id_i    (cand_id_i),
    .cand_util_i  (cand_util_i),
    .sel_valid_o  (sel_valid),
    .sel_id_o     (sel_id)
  );

  genvar k;
  generate
    for (k = 0; k < NUM_CORES; k++) begin : g_slot
      lca_core_slot #(.ID_W(ID_W), .DEPTH(BUF_DEPTH)) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .quantum_i     (quantum_i),
        .q_lt_valid_i  (sel_valid[k]),
        .q_lt_id_i     (sel_id[k*ID_W +: ID_W]),
        .req_i         (eligible && (bn_core_i == CORE_W'(k))),
        .req_id_i      (bn_id_i),
        .done_i        (bn_done_i[k]),
        .grant_valid_o (grant_valid_o[k]),
        .grant_is_bn_o (grant_is_bn_o[k]),
        .grant_id_o    (grant_id_o[k*ID_W +: ID_W]),
        .preempt_o     (preempt_o[k]),
        .restore_o     (restore_o[k]),
        .reject_o      (slot_rej[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= bn_valid_i && !(above && core_ok);
  end

  assign bn_reject_o = drop_q || (|slot_rej);

  assert_low_util_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bn_valid_i && (bn_util_i <= bn_thresh_i)) |=> (bn_reject_o && (preempt_o == '0)));
  assert_single_preempt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(preempt_o));
endmodule

// File: tb/lca_coordinator_tb.sv
module lca_coordinator_tb;
  localparam int NC = 2, NK = 4, IW = 6, UW = 8, DEP = 2;

  logic clk = 1'b0, rst_n = 1'b0, quantum = 1'b0, bn_valid = 1'b0;
  logic [NK-1:0] cand_valid = '0;
  logic [NK*IW-1:0] cand_id = '0;
  logic [NK*UW-1:0] cand_util = '0;
  logic [UW-1:0] thresh = 8'd100, bn_util = '0;
  logic [IW-1:0] bn_id = '0;
  logic [0:0] bn_core = '0;
  logic [NC-1:0] bn_done = '0;
  logic bn_ready, bn_reject;
  logic [NC-1:0] gvalid, gbn, preempt, restore;
  logic [NC*IW-1:0] gid;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lca_coordinator #(.NUM_CORES(NC), .NUM_CAND(NK), .ID_W(IW), .UTIL_W(UW), .BUF_DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .quantum_i(quantum), .cand_valid_i(cand_valid),
    .cand_id_i(cand_id), .cand_util_i(cand_util), .bn_thresh_i(thresh),
    .bn_valid_i(bn_valid), .bn_ready_o(bn_ready), .bn_id_i(bn_id), .bn_util_i(bn_util),
    .bn_core_i(bn_core), .bn_done_i(bn_done), .grant_valid_o(gvalid), .grant_is_bn_o(gbn),
    .grant_id_o(gid), .preempt_o(preempt), .restore_o(restore), .bn_reject_o(bn_reject));

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // core grant check: valid, is_bn, id
  task automatic chk_core(string tag, int c, int v, int b, int id);
    chk({tag, " valid"}, gvalid[c], v);
    chk({tag, " is_bn"}, gbn[c], b);
    if (v != 0) chk({tag, " id"}, gid[c*IW +: IW], id);
  endtask

  task automatic set_cand(int i, int v, int id, int u);
    cand_valid[i] = v[0];
    cand_id[i*IW +: IW] = IW'(id);
    cand_util[i*UW +: UW] = UW'(u);
  endtask

  task automatic do_quantum();
    quantum = 1'b1; tick(); quantum = 1'b0;
  endtask

  task automatic send(int core, int id, int u, int done_mask);
    bn_valid = 1'b1; bn_core = core[0]; bn_id = IW'(id); bn_util = UW'(u);
    bn_done = NC'(done_mask);
    tick();
    bn_valid = 1'b0; bn_done = '0;
  endtask

  task automatic done(int core);
    bn_done[core] = 1'b1; tick(); bn_done = '0;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 ready in reset", bn_ready, 0);
    rst_n = 1'b1; tick();
    chk("R1 grant valid", gvalid, 0);
    chk("R1 preempt", preempt, 0);
    chk("R1 restore", restore, 0);
    chk("R1 reject", bn_reject, 0);
    chk("R1 ready", bn_ready, 1);
  endtask

  task automatic t_ranking();
    set_cand(0, 1, 10, 30); set_cand(1, 1, 11, 90); set_cand(2, 1, 12, 50); set_cand(3, 0, 13, 200);
    do_quantum();
    chk_core("R2 desc c0", 0, 1, 0, 11);
    chk_core("R2 desc c1", 1, 1, 0, 12);
    set_cand(0, 1, 20, 40); set_cand(1, 1, 21, 40); set_cand(2, 0, 0, 0);
    do_quantum();
    chk_core("R2 tie c0", 0, 1, 0, 20);
    chk_core("R2 tie c1", 1, 1, 0, 21);
    set_cand(0, 0, 0, 0); set_cand(1, 0, 0, 0); set_cand(2, 1, 7, 5);
    do_quantum();
    chk_core("R2 single c0", 0, 1, 0, 7);
    chk("R2 idle c1", gvalid[1], 0);
    set_cand(0, 1, 10, 30); set_cand(1, 1, 11, 90); set_cand(2, 1, 12, 50);
    do_quantum();
  endtask

  task automatic t_threshold();
    send(0, 33, 100, 0);
    chk("R3 reject pulse", bn_reject, 1);
    chk("R3 no preempt", preempt, 0);
    chk_core("R3 grant kept", 0, 1, 0, 11);
    tick();
    chk("R3 pulse ends", bn_reject, 0);
  endtask

  task automatic t_preempt();
    send(0, 33, 101, 0);
    chk("R4 preempt c0", preempt, 1);
    chk_core("R4 grant bn", 0, 1, 1, 33);
    chk_core("R10 c1 untouched", 1, 1, 0, 12);
    tick();
    chk("R4 preempt one cycle", preempt, 0);
  endtask

  task automatic t_queue_full_quantum();
    send(0, 34, 150, 0);
    chk_core("R5 enqueue keeps grant", 0, 1, 1, 33);
    send(0, 35, 150, 0);
    chk("R5 no reject", bn_reject, 0);
    send(0, 36, 150, 0);
    chk("R7 full reject", bn_reject, 1);
    chk_core("R7 grant kept", 0, 1, 1, 33);
    set_cand(0, 1, 40, 99); set_cand(1, 1, 41, 10); set_cand(2, 0, 0, 0);
    do_quantum();
    chk_core("R8 bn undisturbed", 0, 1, 1, 33);
    chk_core("R8 lt core updated", 1, 1, 0, 41);
    done(0);
    chk_core("R6 first queued", 0, 1, 1, 34);
    chk("R6 no restore yet", restore, 0);
    done(0);
    chk_core("R7 second queued not 36", 0, 1, 1, 35);
    done(0);
    chk("R6 restore pulse", restore, 1);
    chk_core("R8 restored new lt", 0, 1, 0, 40);
    tick();
    chk("R6 restore one cycle", restore, 0);
    done(0);
    chk("R6 done idle no restore", restore, 0);
    chk_core("R6 done idle grant", 0, 1, 0, 40);
  endtask

  task automatic t_collision();
    send(1, 50, 200, 0);
    chk("R4 preempt c1", preempt, 2);
    chk_core("R10 c0 untouched", 0, 1, 0, 40);
    send(1, 51, 200, 2);
    chk_core("R9 direct handover", 1, 1, 1, 51);
    chk("R9 no preempt", preempt, 0);
    chk("R9 no restore", restore, 0);
    done(1);
    chk("R6 restore c1", restore, 2);
    chk_core("R6 c1 lt back", 1, 1, 0, 41);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_ranking();
    t_threshold();
    t_preempt();
    t_queue_full_quantum();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule